// File: doc/BRIEF.md
# Peripheral-to-Memory DMA Channel with Reloading Shadow Registers

This block is one DMA channel that carries bytes from a peripheral into memory. Each time the peripheral raises a request with a byte, the channel takes that byte and writes it to a memory buffer with a single-beat write. The memory address can step forward after each byte or stay fixed. Software sets up the channel through a small register write port. It programs an item count, the peripheral address, up to two memory base addresses and a control word. The channel keeps these programmed values as shadow copies. It never changes them while it runs.

The channel works from working copies of the count and the memory pointer. These working copies are loaded from the shadow values every time the channel starts, whether the previous run was aborted or ran to its end. In single-shot mode the channel stops after the last item. In circular mode it reloads and keeps going on its own. In double-buffer mode it reloads like circular mode and also swaps between the two memory bases, and an output shows which buffer is being filled. A half-way flag and a completion flag can each drive the interrupt output. A start request is refused until software has cleared both flags.

The remaining count is visible at all times. It counts an item as soon as the byte is taken from the peripheral, which can be before the memory write of that byte has finished.

Top module: `dma_shadow_chan`

## Requirements
- R1: After reset, chan_on, busy, mw_valid, per_ack, flag_ht, flag_tc and irq are low, and remain is zero.
- R2: Every accepted byte is written to memory exactly once, at the working pointer. The pointer advances by one per item when control bit 3 (memory increment) is set and stays fixed otherwise. per_addr shows the value written to select 2. mw_valid, mw_addr and mw_data hold steady until mw_ready is seen.
- R3: remain drops by one in the cycle after each accepted byte, before that byte's memory write completes. At most one accepted byte waits for memory. While it waits with mw_ready low, no further byte is accepted.
- R4: A write to select 0 (control) with bit 0 set, made while the channel is idle, starts a run when a start is permitted. The start loads remain from select 1 (count) and the pointer from select 3 (base 0). This holds whether the previous run was aborted or completed, so a restart without reprogramming begins again at base 0.
- R5: With control bits 1 and 2 both clear, accepting the item that brings remain to zero clears chan_on, and no more bytes are accepted.
- R6: With control bit 1 (circular) set, accepting the last item reloads remain from the count and the pointer from base 0, and chan_on stays high.
- R7: For a programmed count N of 2 or more, flag_ht sets on the acceptance that brings the moved items to floor(N/2). flag_tc sets when the last item is accepted. irq equals (flag_ht AND control bit 4) OR (flag_tc AND control bit 5).
- R8: A start request is ignored while flag_ht or flag_tc is set, or while the programmed count is zero.
- R9: With control bit 2 (double buffer) set, reloads happen automatically as in circular mode. Each reload moves the pointer to the other base (base 1 is select 4) and toggles buf_sel. A start always begins at base 0 with buf_sel at 0.
- R10: A write to control with bit 0 clear while chan_on is high aborts the run: chan_on falls in the next cycle. A byte that was already accepted is still written, and busy stays high until that write is done.
- R11: Writes to control, count, peripheral address and the two base selects are ignored while busy is high, except for the abort described in R10.
- R12: A write to select 5 clears flag_ht when bit 0 is one and flag_tc when bit 1 is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 control, 1 count, 2 peripheral address, 3 base 0, 4 base 1, 5 flag clear) |
| reg_wdata | input | ADDR_W | Register write data |
| per_req | input | 1 | Peripheral has a byte ready |
| per_data | input | DATA_W | Peripheral byte |
| per_ack | output | 1 | Byte taken from the peripheral in this cycle |
| per_addr | output | ADDR_W | Programmed peripheral address |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | ADDR_W | Memory write address |
| mw_data | output | DATA_W | Memory write data |
| remain | output | CNT_W | Working remaining-item count |
| chan_on | output | 1 | Channel enabled |
| busy | output | 1 | Channel enabled or a write still pending |
| buf_sel | output | 1 | Buffer being filled in double-buffer mode |
| flag_ht | output | 1 | Half-transfer flag |
| flag_tc | output | 1 | Transfer-complete flag |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps the count from one to six in single-shot mode, with the pointer either incrementing or fixed and under three patterns of memory stall and peripheral pacing. For each run it works out the buffer contents and the flag state arithmetically. A design that counted only at the memory write, or let a second byte in behind a stalled write, would show the wrong remain value or lose a byte.

Restarts after an abort and after a natural completion must both land at base 0. A design that resumed from the old pointer would leave base 0 untouched. An abort with a byte stuck behind a stalled write must still deliver that byte. Writes made during that drain must not reach the shadow values.

Circular and double-buffer runs span several laps. A wrong wrap would overwrite the wrong slot or miss the buffer swap. Starts attempted with a flag still set, or with a zero count, must leave the channel off.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_PADDR = 3'd2,
        SEL_BASE0 = 3'd3,
        SEL_BASE1 = 3'd4,
        SEL_FCLR  = 3'd5
    } reg_sel_e;

    // control word bit positions
    localparam int CTL_EN   = 0;
    localparam int CTL_CIRC = 1;
    localparam int CTL_DBUF = 2;
    localparam int CTL_MINC = 3;
    localparam int CTL_HTIE = 4;
    localparam int CTL_TCIE = 5;

    typedef struct packed {
        logic tc_ie;
        logic ht_ie;
        logic minc;
        logic dbuf;
        logic circ;
    } mode_t;

    // w holds control bits 5..1
    function automatic mode_t decode_mode(input logic [4:0] w);
        mode_t m;
        m.circ  = w[CTL_CIRC - 1];
        m.dbuf  = w[CTL_DBUF - 1];
        m.minc  = w[CTL_MINC - 1];
        m.ht_ie = w[CTL_HTIE - 1];
        m.tc_ie = w[CTL_TCIE - 1];
        return m;
    endfunction

    // count left in the working counter once floor(n/2) items have moved
    function automatic logic [31:0] ceil_half(input logic [31:0] n);
        return n - (n >> 1);
    endfunction

endpackage

// File: rtl/dsc_cfg.sv
module dsc_cfg
    import dsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              chan_on,
    input  logic              busy,
    input  logic              evt_ht,
    input  logic              evt_tc,
    output logic [CNT_W-1:0]  sh_cnt,
    output logic [ADDR_W-1:0] sh_paddr,
    output logic [ADDR_W-1:0] sh_base0,
    output logic [ADDR_W-1:0] sh_base1,
    output mode_t             mode,
    output logic              start,
    output logic              abort,
    output logic              flag_ht,
    output logic              flag_tc,
    output logic              irq
);

    reg_sel_e sel_e;
    logic     ctl_wr, clr_ht, clr_tc;

    assign sel_e  = reg_sel_e'(reg_sel);
    assign ctl_wr = reg_we && (sel_e == SEL_CTRL);
    assign clr_ht = reg_we && (sel_e == SEL_FCLR) && reg_wdata[0];
    assign clr_tc = reg_we && (sel_e == SEL_FCLR) && reg_wdata[1];

    assign start = ctl_wr && reg_wdata[CTL_EN] && !busy
                   && !flag_ht && !flag_tc && (sh_cnt != '0);
    assign abort = ctl_wr && !reg_wdata[CTL_EN] && chan_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_cnt   <= '0;
            sh_paddr <= '0;
            sh_base0 <= '0;
            sh_base1 <= '0;
            mode     <= '0;
        end else if (reg_we && !busy) begin
            unique case (sel_e)
                SEL_CTRL:  mode     <= decode_mode(reg_wdata[5:1]);
                SEL_COUNT: sh_cnt   <= reg_wdata[CNT_W-1:0];
                SEL_PADDR: sh_paddr <= reg_wdata;
                SEL_BASE0: sh_base0 <= reg_wdata;
                SEL_BASE1: sh_base1 <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_ht <= 1'b0;
            flag_tc <= 1'b0;
        end else begin
            flag_ht <= evt_ht | (flag_ht & ~clr_ht);
            flag_tc <= evt_tc | (flag_tc & ~clr_tc);
        end
    end

    assign irq = (flag_ht & mode.ht_ie) | (flag_tc & mode.tc_ie);

    // shadow values cannot move while a run or a drain is in progress
    assert_shadow_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(sh_cnt) && $stable(sh_base0) && $stable(sh_base1) && $stable(sh_paddr)));

    assert_flag_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (clr_tc && !evt_tc) |=> !flag_tc);

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
        evt_tc |=> flag_tc);

endmodule

// File: rtl/dsc_engine.sv
module dsc_engine
    import dsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              circ,
    input  logic              dbuf,
    input  logic              minc,
    input  logic [CNT_W-1:0]  sh_cnt,
    input  logic [ADDR_W-1:0] sh_base0,
    input  logic [ADDR_W-1:0] sh_base1,
    input  logic              per_req,
    input  logic [DATA_W-1:0] per_data,
    output logic              per_ack,
    output logic              mw_valid,
    input  logic              mw_ready,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [DATA_W-1:0] mw_data,
    output logic [CNT_W-1:0]  remain,
    output logic              chan_on,
    output logic              busy,
    output logic              buf_sel,
    output logic              evt_ht,
    output logic              evt_tc
);

    logic              on_q, stg_v_q, buf_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] ptr_q, stg_addr_q;
    logic [DATA_W-1:0] stg_data_q;

    logic              accept, last, wrap;
    logic [CNT_W-1:0]  half_left;
    logic [ADDR_W-1:0] reload_base;

    assign accept      = on_q && per_req && (!stg_v_q || mw_ready);
    assign last        = (cnt_q == CNT_W'(1));
    assign wrap        = circ | dbuf;
    assign half_left   = CNT_W'(ceil_half(32'(sh_cnt)));
    assign reload_base = (dbuf && !buf_q) ? sh_base1 : sh_base0;

    assign evt_tc = accept && last;
    assign evt_ht = accept && ((cnt_q - CNT_W'(1)) == half_left);

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q       <= 1'b0;
            stg_v_q    <= 1'b0;
            buf_q      <= 1'b0;
            cnt_q      <= '0;
            ptr_q      <= '0;
            stg_addr_q <= '0;
            stg_data_q <= '0;
        end else begin
            if (stg_v_q && mw_ready) stg_v_q <= 1'b0;
            if (accept) begin
                stg_v_q    <= 1'b1;
                stg_addr_q <= ptr_q;
                stg_data_q <= per_data;
                if (last) begin
                    if (wrap) begin
                        cnt_q <= sh_cnt;
                        ptr_q <= reload_base;
                        if (dbuf) buf_q <= ~buf_q;
                    end else begin
                        cnt_q <= '0;
                        on_q  <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (minc) ptr_q <= ptr_q + ADDR_W'(1);
                end
            end
            if (start) begin
                on_q  <= 1'b1;
                cnt_q <= sh_cnt;
                ptr_q <= sh_base0;
                buf_q <= 1'b0;
            end
            if (abort) on_q <= 1'b0;
        end
    end

    assign per_ack  = accept;
    assign mw_valid = stg_v_q;
    assign mw_addr  = stg_addr_q;
    assign mw_data  = stg_data_q;
    assign remain   = cnt_q;
    assign chan_on  = on_q;
    assign busy     = on_q | stg_v_q;
    assign buf_sel  = buf_q;

    assert_write_held_R2: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (per_ack && remain != CNT_W'(1)) |=> (remain == $past(remain) - CNT_W'(1)));

    assert_single_stop_R5: assert property (@(posedge clk) disable iff (rst)
        (per_ack && remain == CNT_W'(1) && !circ && !dbuf) |=> !chan_on);

    assert_circ_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (per_ack && remain == CNT_W'(1) && circ && !abort) |=> (chan_on && remain == $past(sh_cnt)));

    assert_buf_swap_R9: assert property (@(posedge clk) disable iff (rst)
        (per_ack && remain == CNT_W'(1) && dbuf) |=> (buf_sel != $past(buf_sel)));

    assert_abort_stops_R10: assert property (@(posedge clk) disable iff (rst)
        abort |=> !chan_on);

endmodule

// File: rtl/dma_shadow_chan.sv
module dma_shadow_chan
    import dsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              per_req,
    input  logic [DATA_W-1:0] per_data,
    output logic              per_ack,
    output logic [ADDR_W-1:0] per_addr,
    output logic              mw_valid,
    input  logic              mw_ready,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [DATA_W-1:0] mw_data,
    output logic [CNT_W-1:0]  remain,
    output logic              chan_on,
    output logic              busy,
    output logic              buf_sel,
    output logic              flag_ht,
    output logic              flag_tc,
    output logic              irq
);

    logic [CNT_W-1:0]  sh_cnt;
    logic [ADDR_W-1:0] sh_base0, sh_base1;
    mode_t             mode;
    logic              start, abort, evt_ht, evt_tc;

    dsc_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) cfg_i (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .chan_on(chan_on), .busy(busy),
        .evt_ht(evt_ht), .evt_tc(evt_tc),
        .sh_cnt(sh_cnt), .sh_paddr(per_addr),
        .sh_base0(sh_base0), .sh_base1(sh_base1),
        .mode(mode), .start(start), .abort(abort),
        .flag_ht(flag_ht), .flag_tc(flag_tc), .irq(irq)
    );

    dsc_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) eng_i (
        .clk(clk), .rst(rst),
        .start(start), .abort(abort),
        .circ(mode.circ), .dbuf(mode.dbuf), .minc(mode.minc),
        .sh_cnt(sh_cnt), .sh_base0(sh_base0), .sh_base1(sh_base1),
        .per_req(per_req), .per_data(per_data), .per_ack(per_ack),
        .mw_valid(mw_valid), .mw_ready(mw_ready),
        .mw_addr(mw_addr), .mw_data(mw_data),
        .remain(remain), .chan_on(chan_on), .busy(busy), .buf_sel(buf_sel),
        .evt_ht(evt_ht), .evt_tc(evt_tc)
    );

    // a run may only begin once software has cleared both flags
    assert_start_needs_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(chan_on) |-> $past(!flag_ht && !flag_tc));

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (!flag_ht && !flag_tc) |-> !irq);

endmodule

// File: tb/dma_shadow_chan_tb.sv
module dma_shadow_chan_tb_top;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DW = 8;

    localparam logic [2:0] S_CTRL = 3'd0, S_CNT = 3'd1, S_PADDR = 3'd2,
                           S_B0 = 3'd3, S_B1 = 3'd4, S_FCLR = 3'd5;
    localparam int EN = 1, CIRC = 2, DBUF = 4, MINC = 8, HTIE = 16, TCIE = 32;

    logic          clk, rst;
    logic          reg_we;
    logic [2:0]    reg_sel;
    logic [AW-1:0] reg_wdata;
    logic          per_req, per_ack, mw_valid, mw_ready;
    logic [DW-1:0] per_data, mw_data;
    logic [AW-1:0] per_addr, mw_addr;
    logic [CW-1:0] remain;
    logic          chan_on, busy, buf_sel, flag_ht, flag_tc, irq;

    dma_shadow_chan #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .per_req(per_req), .per_data(per_data), .per_ack(per_ack), .per_addr(per_addr),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
        .remain(remain), .chan_on(chan_on), .busy(busy), .buf_sel(buf_sel),
        .flag_ht(flag_ht), .flag_tc(flag_tc), .irq(irq)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, acc = 0, acc_lim = 0, wcnt = 0;
    int rdy_mode = 0, req_mode = 0;
    logic [7:0] nval = 8'h01;
    logic [7:0] mem [256];
    bit done = 0;

    // memory and peripheral models, acting at the falling edge
    initial begin
        per_req  = 1'b0;
        per_data = '0;
        mw_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            case (rdy_mode)
                0: mw_ready = 1'b1;
                1: mw_ready = cyc[0];
                2: mw_ready = (cyc % 3) == 0;
                default: mw_ready = 1'b0;
            endcase
            if (mw_valid && mw_ready) begin
                mem[mw_addr[7:0]] = mw_data;
                wcnt++;
            end
            per_req  = (acc < acc_lim) && ((req_mode == 0) || cyc[0]);
            per_data = nval;
            #1;
            if (per_ack) begin
                nval = nval + 8'd1;
                acc++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input int d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_sel   = s;
        reg_wdata = AW'(d);
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 600 && busy; g++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_acc(input int target);
        for (int g = 0; g < 600 && acc < target; g++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic fill_mem();
        for (int a = 0; a < 256; a++) mem[a] = 8'hEE;
    endtask

    initial begin
        #(10 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] first;
        int w0, a0;
        reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
        rst = 1'b1;
        fill_mem();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 chan_on", int'(chan_on), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 mw_valid", int'(mw_valid), 0);
        chk("R1 per_ack", int'(per_ack), 0);
        chk("R1 flags", int'({flag_ht, flag_tc}), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 remain", int'(remain), 0);

        // sweep of single-shot runs: R2 R5 R7 R12
        for (int n = 1; n <= 6; n++) begin
            for (int mi = 0; mi < 2; mi++) begin
                for (int rm = 0; rm < 3; rm++) begin
                    fill_mem();
                    rdy_mode = rm;
                    req_mode = (rm == 2) ? 1 : 0;
                    acc_lim  = 1 << 30;
                    wr(S_CNT, n); wr(S_PADDR, 16'h0040); wr(S_B0, 16'h0010);
                    first = nval; w0 = wcnt;
                    wr(S_CTRL, EN | HTIE | TCIE | (mi != 0 ? MINC : 0));
                    wait_idle();
                    chk("R2 write count", wcnt - w0, n);
                    chk("R2 per_addr", int'(per_addr), 16'h0040);
                    if (mi != 0) begin
                        for (int i = 0; i < n; i++)
                            chk("R2 incrementing buffer", int'(mem[8'h10 + i]), int'(8'(first + i)));
                        chk("R2 no overrun", int'(mem[8'h10 + n]), 8'hEE);
                    end else begin
                        chk("R2 fixed address", int'(mem[8'h10]), int'(8'(first + n - 1)));
                        chk("R2 fixed neighbour", int'(mem[8'h11]), 8'hEE);
                    end
                    chk("R5 stopped", int'(chan_on), 0);
                    chk("R5 remain zero", int'(remain), 0);
                    chk("R7 tc flag", int'(flag_tc), 1);
                    chk("R7 ht flag", int'(flag_ht), (n >= 2) ? 1 : 0);
                    chk("R7 irq", int'(irq), 1);
                    if (n == 6 && mi == 1 && rm == 2) begin
                        // R8: start refused while flags remain set
                        wr(S_CTRL, EN | MINC);
                        chk("R8 refused with flags", int'(chan_on), 0);
                        chk("R8 remain kept", int'(remain), 0);
                    end
                    wr(S_FCLR, 3);
                    chk("R12 flags cleared", int'({flag_ht, flag_tc}), 0);
                    chk("R12 irq low", int'(irq), 0);
                end
            end
        end

        // R8: zero count refused
        rdy_mode = 0; req_mode = 0;
        wr(S_CNT, 0);
        wr(S_CTRL, EN);
        chk("R8 refused zero count", int'(chan_on), 0);

        // R3 R10 R11: pending byte behind stalled memory, then abort
        fill_mem();
        wr(S_CNT, 8); wr(S_B0, 16'h0020);
        rdy_mode = 3; acc_lim = 1 << 30;
        first = nval; w0 = wcnt; a0 = acc;
        wr(S_CTRL, EN | MINC);
        repeat (6) @(negedge clk);
        chk("R3 single item taken", acc - a0, 1);
        chk("R3 count runs ahead", int'(remain), 7);
        chk("R3 write pending", int'(mw_valid), 1);
        chk("R3 memory not yet written", wcnt - w0, 0);
        acc_lim = acc;
        wr(S_CTRL, MINC);
        chk("R10 channel off", int'(chan_on), 0);
        chk("R10 busy while draining", int'(busy), 1);
        wr(S_CNT, 3); wr(S_B0, 16'h0070);
        rdy_mode = 0;
        wait_idle();
        chk("R10 pending byte written", int'(mem[8'h20]), int'(first));
        chk("R10 single write", wcnt - w0, 1);

        // R4 restart after abort, R11 shadow unchanged
        wr(S_CTRL, EN | MINC | TCIE);
        chk("R4 R11 reload after abort", int'(remain), 8);
        first = nval; acc_lim = 1 << 30;
        wait_idle();
        chk("R4 restart at base", int'(mem[8'h20]), int'(first));
        chk("R4 last slot", int'(mem[8'h27]), int'(8'(first + 7)));
        chk("R11 base write ignored", int'(mem[8'h70]), 8'hEE);
        chk("R7 irq tc only", int'(irq), 1);
        wr(S_FCLR, 3);

        // R4 restart after completion
        acc_lim = acc;
        wr(S_CTRL, EN | MINC);
        chk("R4 reload after completion", int'(remain), 8);
        first = nval; w0 = wcnt;
        acc_lim = acc + 3;
        wait_acc(acc_lim);
        chk("R4 base reused", int'(mem[8'h20]), int'(first));
        chk("R3 remain after three", int'(remain), 5);
        wr(S_CTRL, 0);
        wait_idle();
        chk("R10 aborted", int'(chan_on), 0);
        chk("R10 writes done", wcnt - w0, 3);

        // R6 circular, interrupts masked
        fill_mem();
        wr(S_CNT, 4); wr(S_B0, 16'h0030);
        acc_lim = acc; first = nval;
        wr(S_CTRL, EN | CIRC | MINC);
        acc_lim = acc + 10;
        wait_acc(acc_lim);
        chk("R6 still running", int'(chan_on), 1);
        chk("R6 remain after wrap", int'(remain), 2);
        chk("R6 slot0", int'(mem[8'h30]), int'(8'(first + 8)));
        chk("R6 slot1", int'(mem[8'h31]), int'(8'(first + 9)));
        chk("R6 slot2", int'(mem[8'h32]), int'(8'(first + 6)));
        chk("R6 slot3", int'(mem[8'h33]), int'(8'(first + 7)));
        chk("R7 flags in circular", int'({flag_ht, flag_tc}), 3);
        chk("R7 irq masked", int'(irq), 0);
        wr(S_CTRL, 0);
        wait_idle();
        wr(S_FCLR, 3);

        // R9 double buffer
        fill_mem();
        wr(S_CNT, 3); wr(S_B0, 16'h0050); wr(S_B1, 16'h0060);
        acc_lim = acc; first = nval;
        wr(S_CTRL, EN | DBUF | MINC);
        chk("R9 start buffer", int'(buf_sel), 0);
        acc_lim = acc + 4;
        wait_acc(acc_lim);
        chk("R9 second buffer", int'(buf_sel), 1);
        acc_lim = acc + 3;
        wait_acc(acc_lim);
        chk("R9 back to first", int'(buf_sel), 0);
        chk("R9 b0 slot0", int'(mem[8'h50]), int'(8'(first + 6)));
        chk("R9 b0 slot1", int'(mem[8'h51]), int'(8'(first + 1)));
        chk("R9 b1 slot0", int'(mem[8'h60]), int'(8'(first + 3)));
        chk("R9 b1 slot2", int'(mem[8'h62]), int'(8'(first + 5)));
        chk("R9 running", int'(chan_on), 1);
        wr(S_CTRL, 0);
        wait_idle();
        wr(S_FCLR, 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        done = 1;
        $finish;
    end

endmodule